// File: doc/BRIEF.md
# Static-Memory Interface Low-Power Sequencer

This block sits next to an external static-memory controller and handles its power-saving behaviour. When automatic gating is switched on, it removes the controller's functional clock enable whenever nothing is queued and no access is in flight. It brings the enable back as soon as work shows up. A request that arrives while the clock is gated is never dropped: the requester holds `req_pending` high, the clock enable returns one cycle later, and the request is then accepted.

A clock-and-reset manager can ask the controller to go idle. If the acknowledge feature is switched on, the block stops accepting new requests, waits until the in-flight access finishes, and then raises an acknowledge. The acknowledge stays high until the manager withdraws its request. Before normal operation resumes, the block requires that the external flash power-down/reset pin has been released for at least a programmed number of cycles.

The three settings (auto-gating, acknowledge, wake delay) are held in internal registers. These registers load from dedicated inputs on a write strobe.

Top module: `smc_idle_ctrl`

## Requirements
- R1: After reset, `clk_en` is 1, `idle_ack` is 0, and the auto-gating and acknowledge settings are both 0, so neither idle input has any effect until the settings are written.
- R2: On a clock edge with `cfg_we` at 1, the three settings take the values on `cfg_autogate`, `cfg_idleack` and `cfg_wake_dly`. They act from the next cycle on. With `cfg_we` at 0 they hold.
- R3: While auto-gating is 0, `clk_en` stays 1 whatever `req_pending` and `acc_busy` do.
- R4: While auto-gating is 1, `clk_en` is 0 in the cycle after a cycle in which `req_pending` and `acc_busy` were both 0. Otherwise it is 1.
- R5: A `req_pending` that rises while `clk_en` is 0 brings `clk_en` to 1 one cycle later. The still-pending request is then reported on `req_accept`.
- R6: With the acknowledge setting at 1, a raised `idle_req` first moves the block into draining. `idle_ack` rises only on the edge after a cycle with `acc_busy` at 0.
- R7: With the acknowledge setting at 0, `idle_ack` never rises. If the setting is cleared or `idle_req` is dropped during draining, the block returns to normal operation.
- R8: Once raised, `idle_ack` stays 1 until `idle_req` goes to 0. `req_accept` is 0 while draining, while acknowledged, and while waking up.
- R9: A 0-to-1 transition on `flash_rst_n` loads an 8-bit down-counter with the wake-delay setting. `wake_ready` is 1 exactly when the pin, sampled on the previous edge, was 1 and the counter is 0. The counter reaches 0 `cfg_wake_dly` edges after the loading edge.
- R10: After `idle_req` is withdrawn, normal operation (and `req_accept`) returns only on the edge after a cycle in which `wake_ready` was 1. `req_accept` = `req_pending` & `clk_en` & normal operation & `wake_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the settings |
| cfg_autogate | input | 1 | New auto-gating setting |
| cfg_idleack | input | 1 | New idle-acknowledge setting |
| cfg_wake_dly | input | DLY_W | New wake delay, in cycles |
| req_pending | input | 1 | A request is waiting to be served |
| acc_busy | input | 1 | A memory access is in progress |
| idle_req | input | 1 | Idle request from the clock/reset manager |
| flash_rst_n | input | 1 | Flash power-down/reset pin, low = held in power-down |
| clk_en | output | 1 | Functional clock enable for the controller |
| idle_ack | output | 1 | Idle acknowledge to the manager |
| wake_ready | output | 1 | Wake delay after pin release has elapsed |
| req_accept | output | 1 | Pending request may be started this cycle |

## Verification
The bench builds the block with the default 8-bit delay field. This lets directed delays of 0, 5 and 255 cycles run, which covers the zero-delay shortcut, an ordinary countdown and the full-scale value. Random stretches with short delays put pin releases inside the idle, wake and drain phases. A behavioural model compares all four outputs on every cycle, so each of those interleavings is checked.

// File: rtl/smc_idle_pkg.sv
package smc_idle_pkg;

  typedef enum logic [1:0] {
    IDL_RUN   = 2'd0,
    IDL_DRAIN = 2'd1,
    IDL_ACK   = 2'd2,
    IDL_WAKE  = 2'd3
  } idl_state_e;

  // gate request for the next cycle: only with gating on and no activity
  function automatic logic gate_next(input logic auto_en,
                                     input logic pend,
                                     input logic busy);
    return auto_en & ~pend & ~busy;
  endfunction

  // idle handshake transition
  function automatic idl_state_e idl_next(input idl_state_e s,
                                          input logic ireq,
                                          input logic ack_en,
                                          input logic busy,
                                          input logic ready);
    idl_state_e n;
    n = s;
    unique case (s)
      IDL_RUN:   if (ireq && ack_en) n = IDL_DRAIN;
      IDL_DRAIN: begin
        if (!ireq || !ack_en) n = IDL_RUN;
        else if (!busy)       n = IDL_ACK;
      end
      IDL_ACK:   if (!ireq) n = IDL_WAKE;
      IDL_WAKE: begin
        if (ireq)       n = IDL_DRAIN;
        else if (ready) n = IDL_RUN;
      end
      default:   n = IDL_RUN;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/smc_cfg_regs.sv
module smc_cfg_regs #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             autogate_d,
  input  logic             idleack_d,
  input  logic [DLY_W-1:0] dly_d,
  output logic             autogate_q,
  output logic             idleack_q,
  output logic [DLY_W-1:0] dly_q
);

  localparam logic [DLY_W-1:0] DLY_RST = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      autogate_q <= 1'b0;
      idleack_q  <= 1'b0;
      dly_q      <= DLY_RST;
    end else if (we) begin
      autogate_q <= autogate_d;
      idleack_q  <= idleack_d;
      dly_q      <= dly_d;
    end
  end

endmodule

// File: rtl/smc_autogate.sv
module smc_autogate
  import smc_idle_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic pend,
  input  logic busy,
  output logic gated_q
);

  logic gate_d;

  assign gate_d = gate_next(auto_en, pend, busy);

  always_ff @(posedge clk) begin
    if (!rst_n) gated_q <= 1'b0;
    else        gated_q <= gate_d;
  end

endmodule

// File: rtl/smc_idle_fsm.sv
module smc_idle_fsm
  import smc_idle_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ireq,
  input  logic       ack_en,
  input  logic       busy,
  input  logic       ready,
  output idl_state_e state_q,
  output logic       ack,
  output logic       in_run
);

  idl_state_e state_d;

  assign state_d = idl_next(state_q, ireq, ack_en, busy, ready);

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= IDL_RUN;
    else        state_q <= state_d;
  end

  assign ack    = (state_q == IDL_ACK);
  assign in_run = (state_q == IDL_RUN);

endmodule

// File: rtl/smc_wake_timer.sv
module smc_wake_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic [DLY_W-1:0] dly,
  output logic             load,
  output logic             ready
);

  localparam logic [DLY_W-1:0] CNT_ZERO = '0;
  localparam logic [DLY_W-1:0] CNT_ONE  = {{(DLY_W-1){1'b0}}, 1'b1};

  logic             pin_q;
  logic [DLY_W-1:0] cnt_q;

  assign load = pin & ~pin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      cnt_q <= CNT_ZERO;
    end else begin
      pin_q <= pin;
      if (load)                  cnt_q <= dly;
      else if (cnt_q != CNT_ZERO) cnt_q <= cnt_q - CNT_ONE;
    end
  end

  assign ready = pin_q & (cnt_q == CNT_ZERO);

endmodule

// File: rtl/smc_idle_ctrl.sv
module smc_idle_ctrl
  import smc_idle_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_autogate,
  input  logic             cfg_idleack,
  input  logic [DLY_W-1:0] cfg_wake_dly,
  input  logic             req_pending,
  input  logic             acc_busy,
  input  logic             idle_req,
  input  logic             flash_rst_n,
  output logic             clk_en,
  output logic             idle_ack,
  output logic             wake_ready,
  output logic             req_accept
);

  // named internal events, visible to the bound checker
  logic             autogate_on;
  logic             idleack_on;
  logic [DLY_W-1:0] wake_dly_q;
  logic             gated;
  logic             pin_load;
  logic             run_mode;
  idl_state_e       idl_state;

  smc_cfg_regs #(.DLY_W(DLY_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (cfg_we),
    .autogate_d (cfg_autogate),
    .idleack_d  (cfg_idleack),
    .dly_d      (cfg_wake_dly),
    .autogate_q (autogate_on),
    .idleack_q  (idleack_on),
    .dly_q      (wake_dly_q)
  );

  smc_autogate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .auto_en (autogate_on),
    .pend    (req_pending),
    .busy    (acc_busy),
    .gated_q (gated)
  );

  smc_wake_timer #(.DLY_W(DLY_W)) u_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (flash_rst_n),
    .dly   (wake_dly_q),
    .load  (pin_load),
    .ready (wake_ready)
  );

  smc_idle_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .ireq    (idle_req),
    .ack_en  (idleack_on),
    .busy    (acc_busy),
    .ready   (wake_ready),
    .state_q (idl_state),
    .ack     (idle_ack),
    .in_run  (run_mode)
  );

  assign clk_en     = ~gated;
  assign req_accept = req_pending & clk_en & run_mode & wake_ready;

endmodule

// File: rtl/smc_idle_ctrl_chk.sv
module smc_idle_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic autogate_on,
  input logic idleack_on,
  input logic req_pending,
  input logic acc_busy,
  input logic idle_req,
  input logic flash_rst_n,
  input logic clk_en,
  input logic idle_ack,
  input logic wake_ready,
  input logic req_accept
);

  a_r3_clock_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !autogate_on |=> clk_en);

  a_r4_gate_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (autogate_on && !req_pending && !acc_busy) |=> !clk_en);

  a_r5_request_wakes_clock: assert property (@(posedge clk) disable iff (!rst_n)
    req_pending |=> clk_en);

  a_r6_ack_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_ack) |-> !$past(acc_busy));

  a_r7_no_ack_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!idleack_on && !idle_ack) |=> !idle_ack);

  a_r8_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_ack && idle_req) |=> idle_ack);

  a_r8_no_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ack |-> !req_accept);

  a_r9_ready_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ready |-> $past(flash_rst_n));

  a_r10_accept_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> (wake_ready && clk_en && req_pending));

endmodule

bind smc_idle_ctrl smc_idle_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .autogate_on (autogate_on),
  .idleack_on  (idleack_on),
  .req_pending (req_pending),
  .acc_busy    (acc_busy),
  .idle_req    (idle_req),
  .flash_rst_n (flash_rst_n),
  .clk_en      (clk_en),
  .idle_ack    (idle_ack),
  .wake_ready  (wake_ready),
  .req_accept  (req_accept)
);

// File: tb/test_smc_idle_ctrl.sv
module test_smc_idle_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DLY_W      = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic             cfg_autogate = 1'b0;
  logic             cfg_idleack = 1'b0;
  logic [DLY_W-1:0] cfg_wake_dly = '0;
  logic             req_pending = 1'b0;
  logic             acc_busy = 1'b0;
  logic             idle_req = 1'b0;
  logic             flash_rst_n = 1'b1;
  logic             clk_en, idle_ack, wake_ready, req_accept;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smc_idle_ctrl #(.DLY_W(DLY_W)) i_smc_idle_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_autogate (cfg_autogate),
    .cfg_idleack  (cfg_idleack),
    .cfg_wake_dly (cfg_wake_dly),
    .req_pending  (req_pending),
    .acc_busy     (acc_busy),
    .idle_req     (idle_req),
    .flash_rst_n  (flash_rst_n),
    .clk_en       (clk_en),
    .idle_ack     (idle_ack),
    .wake_ready   (wake_ready),
    .req_accept   (req_accept)
  );

  // ---------------- behavioural reference ----------------
  // phase: 0 normal, 1 draining, 2 acknowledged, 3 waking
  int m_phase = 0;
  int m_count = 0;
  bit m_pin_seen = 0;
  bit m_gated = 0;
  bit m_ag = 0, m_ia = 0;
  int m_dly = 0;

  function automatic bit m_ready();
    return m_pin_seen && (m_count == 0);
  endfunction

  always @(posedge clk) begin
    int  nphase, ncount, ndly;
    bit  ngated, nag, nia;
    if (!rst_n) begin
      m_phase = 0; m_count = 0; m_pin_seen = 0; m_gated = 0;
      m_ag = 0; m_ia = 0; m_dly = 0;
    end else begin
      ngated = m_ag && !req_pending && !acc_busy;
      ncount = m_count;
      if (flash_rst_n && !m_pin_seen) ncount = m_dly;
      else if (m_count > 0)           ncount = m_count - 1;
      nphase = m_phase;
      case (m_phase)
        0: if (idle_req && m_ia) nphase = 1;
        1: if (!idle_req || !m_ia) nphase = 0; else if (!acc_busy) nphase = 2;
        2: if (!idle_req) nphase = 3;
        default: if (idle_req) nphase = 1; else if (m_ready()) nphase = 0;
      endcase
      nag = m_ag; nia = m_ia; ndly = m_dly;
      if (cfg_we) begin nag = cfg_autogate; nia = cfg_idleack; ndly = int'(cfg_wake_dly); end
      m_gated = ngated; m_count = ncount; m_phase = nphase;
      m_pin_seen = flash_rst_n;
      m_ag = nag; m_ia = nia; m_dly = ndly;
    end
  end

  task automatic check(input bit act, input bit exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(clk_en,     !m_gated,                                        "R4", "clk_en vs model");
      check(idle_ack,   m_phase == 2,                                    "R8", "idle_ack vs model");
      check(wake_ready, m_ready(),                                       "R9", "wake_ready vs model");
      check(req_accept, req_pending && !m_gated && m_phase == 0 && m_ready(), "R10", "req_accept vs model");
    end
  end

  // inputs change just after a rising edge
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  task automatic write_cfg(input bit ag, input bit ia, input int dly);
    cfg_autogate = ag; cfg_idleack = ia; cfg_wake_dly = DLY_W'(dly); cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    #1;
    at_neg();
    check(clk_en,   1'b1, "R1", "clk_en after reset");
    check(idle_ack, 1'b0, "R1", "idle_ack after reset");

    // settings cleared: idle inputs do nothing
    idle_req = 1'b1;
    step(4); at_neg();
    check(clk_en,   1'b1, "R3", "no gating with setting clear");
    check(idle_ack, 1'b0, "R7", "no ack with setting clear");
    req_pending = 1'b1; acc_busy = 1'b1;
    step(2);
    req_pending = 1'b0; acc_busy = 1'b0;
    step(2); at_neg();
    check(clk_en, 1'b1, "R3", "gating stays off");
    idle_req = 1'b0;
    step(2);

    // write settings: gating on, ack off
    write_cfg(1'b1, 1'b0, 0);
    step(2); at_neg();
    check(clk_en, 1'b0, "R2", "written gating takes effect");
    check(clk_en, 1'b0, "R4", "clock removed when quiet");

    // request while gated
    step();
    req_pending = 1'b1;
    at_neg();
    check(clk_en,     1'b0, "R5", "still gated in arrival cycle");
    check(req_accept, 1'b0, "R5", "no accept while gated");
    step(); at_neg();
    check(clk_en,     1'b1, "R5", "clock back next cycle");
    check(req_accept, 1'b1, "R5", "request kept and accepted");
    req_pending = 1'b0;
    step(3);

    // ack setting on, drain with busy access
    write_cfg(1'b1, 1'b1, 5);
    acc_busy = 1'b1; idle_req = 1'b1;
    step(4); at_neg();
    check(idle_ack, 1'b0, "R6", "no ack while access busy");
    req_pending = 1'b1;
    at_neg();
    check(req_accept, 1'b0, "R8", "no accept while draining");
    acc_busy = 1'b0; req_pending = 1'b0;
    step(); at_neg();
    check(idle_ack, 1'b1, "R6", "ack after access done");
    req_pending = 1'b1;
    step(5); at_neg();
    check(idle_ack,   1'b1, "R8", "ack held while requested");
    check(req_accept, 1'b0, "R8", "no accept while acknowledged");
    req_pending = 1'b0;

    // power-down pin cycle with delay 5
    flash_rst_n = 1'b0;
    step(2); at_neg();
    check(wake_ready, 1'b0, "R9", "not ready while pin low");
    idle_req = 1'b0;
    step(); at_neg();
    check(idle_ack, 1'b0, "R8", "ack drops with request");
    flash_rst_n = 1'b1;
    req_pending = 1'b1;
    step(3); at_neg();
    check(wake_ready, 1'b0, "R9", "counting down");
    check(req_accept, 1'b0, "R10", "no accept before delay");
    step(6); at_neg();
    check(wake_ready, 1'b1, "R9", "ready after delay");
    check(req_accept, 1'b1, "R10", "accept after wake");
    req_pending = 1'b0;

    // full-scale delay
    write_cfg(1'b0, 1'b1, 255);
    flash_rst_n = 1'b0; step(2);
    flash_rst_n = 1'b1; step(200); at_neg();
    check(wake_ready, 1'b0, "R9", "long delay still counting");
    step(60); at_neg();
    check(wake_ready, 1'b1, "R9", "long delay elapsed");

    // drain aborted by clearing ack setting
    acc_busy = 1'b1; idle_req = 1'b1;
    step(3);
    write_cfg(1'b0, 1'b0, 0);
    acc_busy = 1'b0;
    step(3); at_neg();
    check(idle_ack, 1'b0, "R7", "drain abandoned when setting cleared");
    idle_req = 1'b0;
    step(2);

    // random interleavings, model compared each cycle
    for (int i = 0; i < 6000; i++) begin
      req_pending = ($urandom_range(0, 3) == 0);
      acc_busy    = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 40) == 0) idle_req = ~idle_req;
      if ($urandom_range(0, 60) == 0) flash_rst_n = ~flash_rst_n;
      cfg_we = ($urandom_range(0, 150) == 0);
      cfg_autogate = $urandom_range(0, 1) != 0;
      cfg_idleack  = $urandom_range(0, 3) != 0;
      cfg_wake_dly = DLY_W'($urandom_range(0, 12));
      step();
    end
    cfg_we = 1'b0;
    step(2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule